// File: doc/BRIEF.md
# Burst SRAM Write-Access Controller

This block is the front-end control of a synchronous, common-I/O burst SRAM. It looks at two address strobes on each rising clock edge: a processor strobe and a controller strobe. It also looks at three chip enables, a global write, a byte-write enable, per-byte write selects and an output enable. From these it decides whether to capture the address, which byte lanes of the memory array to write, and whether the shared data bus may be driven. A small behavioural array of byte lanes sits behind it, with one registered read word.

A write can start from either strobe, and the two start with different latencies. The processor strobe spends its first cycle capturing the address only. The write controls and data that count are the ones present at the following edge, and that edge writes to the captured address. The controller strobe decodes the write controls in its own cycle and finishes the access at that same edge, at the address on the pins. An access that reaches completion without any byte selected for writing is a read. Its word appears on the output in the next cycle.

Top module: `bsram_wr_ctrl`

## Requirements
- R1: After reset, `byte_we_o` is 0, `addr_ld_o` is 0 and `dq_oe_o` is 0.
- R2: A processor start is `proc_strobe_n` low while the chip is selected and no processor access is pending. Its cycle raises `addr_ld_o` and writes no byte, whatever `all_wr_n`, `byte_wr_en_n` and `byte_sel_n` hold.
- R3: In the cycle after a processor start, the write controls and `dq_i` of that cycle are applied at the address captured in the start cycle. `addr_i` and both strobes are ignored in that cycle, and `addr_ld_o` stays low.
- R4: A controller access needs all of these: `ctrl_strobe_n` low, `proc_strobe_n` high, `ce_a_n` low, `ce_b` high and `ce_c_n` low. It completes at the same edge at `addr_i`. If any chip enable is inactive, nothing is loaded and nothing is written.
- R5: The byte mask decodes as follows. `all_wr_n` low writes all four bytes, whatever `byte_wr_en_n` holds. Otherwise `byte_wr_en_n` low writes byte i exactly when `byte_sel_n[i]` is low. Otherwise no byte is written. Byte i is data bits 8i+7 down to 8i.
- R6: In a byte write, the bytes that are not selected keep their previous contents.
- R7: When both strobes are low in a selected cycle, the access follows the processor path.
- R8: An access that completes with no byte written is a read. In the next cycle `dq_o` holds the array word at that address, and `dq_oe_o` is high if `oe_n` is low.
- R9: `dq_oe_o` is low in every cycle in which any bit of `byte_we_o` is high, whatever `oe_n` holds.
- R10: While `oe_n` is high, `dq_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | 8*NBYTES | Write data from the bus |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Global write of all bytes, active low |
| byte_wr_en_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | NBYTES | Per-byte write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_ld_o | output | 1 | Address register loads at this edge |
| byte_we_o | output | NBYTES | Per-byte write strobes to the array |
| dq_o | output | 8*NBYTES | Registered read word |
| dq_oe_o | output | 1 | Data-bus driver enable |

## Verification
Suppose the pending flag of the processor path is wrong. The byte strobes would then appear in the strobe cycle instead of the next one, or a later strobe would load a new address. Either shows on `byte_we_o` or `addr_ld_o` within the same cycle. A wrong captured address or a wrong mask decode leaves no trace until the word is read back, so every write in the bench is followed by a controller read. That read compares the whole word one cycle later against a model of the array, which catches lanes that were written by mistake and lanes that were missed. Bus contention shows on `dq_oe_o` in the first write cycle that follows a read.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_PSTART = 2'd1,
        ACC_WRITE  = 2'd2,
        ACC_READ   = 2'd3
    } acc_e;

endpackage

// File: rtl/bsram_acc_decode.sv
module bsram_acc_decode
    import bsram_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              pend_i,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              all_wr_n,
    input  logic              byte_wr_en_n,
    input  logic [NBYTES-1:0] byte_sel_n,
    output acc_e              acc_o,
    output logic [NBYTES-1:0] mask_o
);

    logic              chip_sel;
    logic [NBYTES-1:0] ctl_mask;

    assign chip_sel = !ce_a_n && ce_b && !ce_c_n;

    // global write wins over byte-write enable
    always_comb begin
        for (int i = 0; i < NBYTES; i++) begin
            if (!all_wr_n)
                ctl_mask[i] = 1'b1;
            else if (!byte_wr_en_n)
                ctl_mask[i] = !byte_sel_n[i];
            else
                ctl_mask[i] = 1'b0;
        end
    end

    always_comb begin
        acc_o  = ACC_NONE;
        mask_o = '0;
        if (pend_i) begin
            mask_o = ctl_mask;
            acc_o  = (|ctl_mask) ? ACC_WRITE : ACC_READ;
        end else if (chip_sel && !proc_strobe_n) begin
            acc_o  = ACC_PSTART;
        end else if (chip_sel && !ctrl_strobe_n) begin
            mask_o = ctl_mask;
            acc_o  = (|ctl_mask) ? ACC_WRITE : ACC_READ;
        end
    end

endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANE_W-1:0] wdata_i,
    output logic [LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i)
            cells[addr_i] <= wdata_i;
    end

    assign rdata_o = cells[addr_i];

endmodule

// File: rtl/bsram_wr_ctrl.sv
module bsram_wr_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [8*NBYTES-1:0]   dq_i,
    input  logic                  proc_strobe_n,
    input  logic                  ctrl_strobe_n,
    input  logic                  ce_a_n,
    input  logic                  ce_b,
    input  logic                  ce_c_n,
    input  logic                  all_wr_n,
    input  logic                  byte_wr_en_n,
    input  logic [NBYTES-1:0]     byte_sel_n,
    input  logic                  oe_n,
    output logic                  addr_ld_o,
    output logic [NBYTES-1:0]     byte_we_o,
    output logic [8*NBYTES-1:0]   dq_o,
    output logic                  dq_oe_o
);

    localparam int LANE_W = 8;
    localparam int DATA_W = LANE_W * NBYTES;

    typedef struct packed {
        logic              pend;
        logic              rvld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rdat;
    } st_t;

    st_t st_d, st_q;

    acc_e              acc;
    logic [NBYTES-1:0] mask;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_rd;

    bsram_acc_decode #(.NBYTES(NBYTES)) u_dec (
        .pend_i        (st_q.pend),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .ce_a_n        (ce_a_n),
        .ce_b          (ce_b),
        .ce_c_n        (ce_c_n),
        .all_wr_n      (all_wr_n),
        .byte_wr_en_n  (byte_wr_en_n),
        .byte_sel_n    (byte_sel_n),
        .acc_o         (acc),
        .mask_o        (mask)
    );

    // second cycle of a processor access uses the captured address
    assign arr_addr = st_q.pend ? st_q.addr : addr_i;

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_lane
            bsram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
                .clk     (clk),
                .we_i    (byte_we_o[b]),
                .addr_i  (arr_addr),
                .wdata_i (dq_i[b*LANE_W +: LANE_W]),
                .rdata_o (arr_rd[b*LANE_W +: LANE_W])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        byte_we_o = (acc == ACC_WRITE) ? mask : '0;
        addr_ld_o = (acc == ACC_PSTART) ||
                    (!st_q.pend && (acc == ACC_WRITE || acc == ACC_READ));
        st_d.pend = (acc == ACC_PSTART);
        st_d.rvld = (acc == ACC_READ);
        if (addr_ld_o)
            st_d.addr = addr_i;
        if (acc == ACC_READ)
            st_d.rdat = arr_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dq_o    = st_q.rdat;
    assign dq_oe_o = !oe_n && st_q.rvld && !(|byte_we_o);

    // R2
    pstart_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ld_o && !proc_strobe_n && !st_q.pend) |-> (byte_we_o == '0));

    // R3
    pend_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> !addr_ld_o);

    // R4
    ctrl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|byte_we_o) && !st_q.pend) |->
        (!ce_a_n && ce_b && !ce_c_n && proc_strobe_n && !ctrl_strobe_n));

    // R9
    wr_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|byte_we_o) |-> !dq_oe_o);

    // R10
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe_o);

endmodule

// File: tb/bsram_wr_ctrl_bench.sv
module bsram_wr_ctrl_bench;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int DW = 8 * NB;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic [DW-1:0] dq_i;
    logic          proc_strobe_n, ctrl_strobe_n;
    logic          ce_a_n, ce_b, ce_c_n;
    logic          all_wr_n, byte_wr_en_n;
    logic [NB-1:0] byte_sel_n;
    logic          oe_n;
    logic          addr_ld_o;
    logic [NB-1:0] byte_we_o;
    logic [DW-1:0] dq_o;
    logic          dq_oe_o;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] sb [1 << AW];

    always #4 clk = ~clk;

    bsram_wr_ctrl #(.ADDR_W(AW), .NBYTES(NB)) u_bsram_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .dq_i(dq_i),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .all_wr_n(all_wr_n), .byte_wr_en_n(byte_wr_en_n),
        .byte_sel_n(byte_sel_n), .oe_n(oe_n),
        .addr_ld_o(addr_ld_o), .byte_we_o(byte_we_o),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    typedef struct packed {
        logic          proc;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          gw_n;
        logic          bwe_n;
        logic [NB-1:0] sel_n;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 8'h03, 32'h11223344, 1'b0, 1'b1, 4'hF},
        '{1'b1, 8'h04, 32'hA5A5A5A5, 1'b0, 1'b1, 4'hF},
        '{1'b0, 8'h03, 32'hDEADBEEF, 1'b1, 1'b0, 4'b1010},
        '{1'b1, 8'h04, 32'h00FF00FF, 1'b1, 1'b0, 4'b0101},
        '{1'b0, 8'h03, 32'hFFFFFFFF, 1'b1, 1'b1, 4'h0},
        '{1'b0, 8'h03, 32'h00000000, 1'b0, 1'b0, 4'hF},
        '{1'b1, 8'hFF, 32'hCAFEF00D, 1'b0, 1'b1, 4'h0},
        '{1'b1, 8'h04, 32'h12345678, 1'b1, 1'b0, 4'b1110}
    };

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] exp_mask(input logic gw_n, input logic bwe_n,
                                               input logic [NB-1:0] sel_n);
        if (!gw_n)       return '1;
        else if (!bwe_n) return ~sel_n;
        else             return '0;
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input logic [NB-1:0] m);
        for (int b = 0; b < NB; b++)
            if (m[b]) sb[a][b*8 +: 8] = d[b*8 +: 8];
    endtask

    task automatic idle();
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1;
        ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
        all_wr_n = 1'b1; byte_wr_en_n = 1'b1; byte_sel_n = '1;
        oe_n = 1'b0; addr_i = '0; dq_i = '0;
    endtask

    // controller-strobe read, then check the word one cycle later
    task automatic read_back(input logic [AW-1:0] a, input string req);
        idle();
        ctrl_strobe_n = 1'b0; addr_i = a;
        @(negedge clk);
        idle();
        #1;
        check({req, " read oe"}, {31'd0, dq_oe_o}, 32'd1);
        check({req, " read data"}, dq_o, sb[a]);
        @(negedge clk);
    endtask

    initial begin
        #1_600_000;
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        check("R1 we", {28'd0, byte_we_o}, 32'd0);
        check("R1 ld", {31'd0, addr_ld_o}, 32'd0);
        check("R1 oe", {31'd0, dq_oe_o}, 32'd0);
        @(negedge clk);

        // table walk: R5, R6, R2, R3
        foreach (VEC[k]) begin
            logic [NB-1:0] m;
            m = exp_mask(VEC[k].gw_n, VEC[k].bwe_n, VEC[k].sel_n);
            idle();
            if (VEC[k].proc) begin
                proc_strobe_n = 1'b0; addr_i = VEC[k].a;
                all_wr_n = 1'b0; byte_wr_en_n = 1'b0; byte_sel_n = '0;
                #1;
                check("R2 first cycle no write", {28'd0, byte_we_o}, 32'd0);
                @(negedge clk);
                idle();
                addr_i = VEC[k].a ^ 8'h5A;
            end else begin
                ctrl_strobe_n = 1'b0; addr_i = VEC[k].a;
            end
            dq_i = VEC[k].d;
            all_wr_n = VEC[k].gw_n; byte_wr_en_n = VEC[k].bwe_n;
            byte_sel_n = VEC[k].sel_n;
            #1;
            check("R5 mask", {28'd0, byte_we_o}, {28'd0, m});
            model_write(VEC[k].a, VEC[k].d, m);
            @(negedge clk);
            read_back(VEC[k].a, "R6 R3");
        end

        // R4: chip enables gate the controller strobe
        idle();
        ctrl_strobe_n = 1'b0; addr_i = 8'h03; all_wr_n = 1'b0;
        dq_i = 32'hBADBAD00; ce_b = 1'b0;
        #1;
        check("R4 ce_b off we", {28'd0, byte_we_o}, 32'd0);
        check("R4 ce_b off ld", {31'd0, addr_ld_o}, 32'd0);
        @(negedge clk);
        idle();
        ctrl_strobe_n = 1'b0; addr_i = 8'h03; all_wr_n = 1'b0;
        dq_i = 32'hBADBAD00; ce_a_n = 1'b1;
        #1;
        check("R4 ce_a off we", {28'd0, byte_we_o}, 32'd0);
        @(negedge clk);
        read_back(8'h03, "R4");

        // R7 + R3: both strobes low follow the processor path
        idle();
        proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; addr_i = 8'h05;
        all_wr_n = 1'b0;
        #1;
        check("R7 ld", {31'd0, addr_ld_o}, 32'd1);
        check("R7 no write", {28'd0, byte_we_o}, 32'd0);
        @(negedge clk);
        idle();
        ctrl_strobe_n = 1'b0; proc_strobe_n = 1'b0; addr_i = 8'h06;
        all_wr_n = 1'b0; dq_i = 32'h55667788;
        #1;
        check("R3 strobe ignored ld", {31'd0, addr_ld_o}, 32'd0);
        check("R3 mask", {28'd0, byte_we_o}, 32'hF);
        model_write(8'h05, 32'h55667788, 4'hF);
        @(negedge clk);
        read_back(8'h05, "R3");

        // R9: write right after a read keeps the bus off
        idle();
        ctrl_strobe_n = 1'b0; addr_i = 8'h03;
        @(negedge clk);
        idle();
        ctrl_strobe_n = 1'b0; addr_i = 8'h09; all_wr_n = 1'b0;
        dq_i = 32'h0BADF00D;
        #1;
        check("R9 bus off in write", {31'd0, dq_oe_o}, 32'd0);
        check("R9 write strobes", {28'd0, byte_we_o}, 32'hF);
        model_write(8'h09, 32'h0BADF00D, 4'hF);
        @(negedge clk);
        read_back(8'h09, "R9");

        // R10 + R8: oe_n high blocks the bus, data still held
        idle();
        ctrl_strobe_n = 1'b0; addr_i = 8'h04; oe_n = 1'b1;
        @(negedge clk);
        idle();
        oe_n = 1'b1;
        #1;
        check("R10 oe high", {31'd0, dq_oe_o}, 32'd0);
        oe_n = 1'b0;
        #1;
        check("R8 oe low", {31'd0, dq_oe_o}, 32'd1);
        check("R8 data", dq_o, sb[8'h04]);
        @(negedge clk);
        #1;
        check("R8 one cycle only", {31'd0, dq_oe_o}, 32'd0);

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule